// File: doc/BRIEF.md
# Two-Weight Fixed-Point LMS Adaptive Combiner

This block adapts two signed fixed-point weights with the least-mean-squares rule, one step per sample strobe. A single sample stream feeds both taps: the first tap sees the current sample and the second sees the sample from a fixed number of strobes earlier. A desired reference sample arrives with each strobe. The block forms the weighted sum from the weights held before the strobe, takes the error against the reference, and moves each weight by the step size times its tap sample times the error.

The full-width increment is rounded and saturated back to the weight format before it is stored, so the weight registers keep one word format no matter how many steps run. Adaptation stops after a parameterized number of updates; after that the weights freeze, while output and error are still produced for every strobe.

Top module: `lms2_core`

## Requirements
- R1: A synchronous active-high reset clears both weights, the update counter, the tap delay line, the output and error registers and the output valid flag.
- R2: The output valid flag is high in exactly the cycle after a cycle in which the sample strobe is high, and output, error and weights are all registered.
- R3: The output is x1·w1 + x2·w2 computed with the weights held before the strobe; samples and weights are signed with 5 fraction bits (12 bits wide), the output is signed with 10 fraction bits (25 bits wide).
- R4: The error equals the output minus the reference sample, both with 10 fraction bits; the error is 26 bits wide.
- R5: While adapting, each weight becomes w + q where q is the product step·tap·error requantized to 5 fraction bits; the step is the raw value 2 with 5 fraction bits (0.0625, the nearest such value to 0.05).
- R6: Requantization rounds to nearest with a tie rounding toward positive infinity: q = floor((step·tap·error + 2^14) / 2^15).
- R7: The updated weight saturates to 2047 (raw) when the sum is above it and to -2048 when below.
- R8: The second tap uses the sample taken 30 strobes earlier, and zero until 30 strobes have passed since reset.
- R9: After 1000 updates the weights freeze; later strobes still produce output and error.
- R10: In a cycle without a strobe no weight, output or error register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe |
| smp_x | input | 12 | Current tap sample, signed, 5 fraction bits |
| smp_ref | input | 25 | Desired reference, signed, 10 fraction bits |
| out_vld | output | 1 | Output valid, one cycle after the strobe |
| out_y | output | 25 | Filter output, signed, 10 fraction bits |
| out_err | output | 26 | Error, signed, 10 fraction bits |
| out_w1 | output | 12 | First weight, signed, 5 fraction bits |
| out_w2 | output | 12 | Second weight, signed, 5 fraction bits |

## Verification
The embedded assertions watch, every cycle, the one-cycle valid latency, the error being the output minus the reference that was presented, the weights and output holding still between strobes, and the weights staying fixed once the update count is reached. The arithmetic itself, meaning the pre-update weights used for the output, the rounding tie toward positive infinity, the saturation at both limits and the 30-strobe tap delay, is shown only by the bench's directed scenarios compared against an independent numeric model.

// File: rtl/lms2_core.sv
module lms2_core #(
  parameter int XW      = 12,
  parameter int XF      = 5,
  parameter int MUW     = 9,
  parameter int MUF     = 5,
  parameter int MU_RAW  = 2,
  parameter int YW      = 25,
  parameter int DLY     = 30,
  parameter int MAX_UPD = 1000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_vld,
  input  logic signed [XW-1:0] smp_x,
  input  logic signed [YW-1:0] smp_ref,
  output logic                 out_vld,
  output logic signed [YW-1:0] out_y,
  output logic signed [YW:0]   out_err,
  output logic signed [XW-1:0] out_w1,
  output logic signed [XW-1:0] out_w2
);
  localparam int EW = YW + 1;
  localparam int PF = MUF + 3 * XF;
  localparam int SH = PF - XF;
  localparam int PW = MUW + XW + EW;
  localparam int CW = $clog2(MAX_UPD + 1);
  localparam logic signed [MUW-1:0] MU   = MUW'(MU_RAW);
  localparam logic signed [XW-1:0]  WMAX = {1'b0, {(XW-1){1'b1}}};
  localparam logic signed [XW-1:0]  WMIN = {1'b1, {(XW-1){1'b0}}};

  logic signed [XW-1:0]   w1_q, w2_q;
  logic signed [XW-1:0]   dly_q [DLY];
  logic [CW-1:0]          cnt_q;
  logic signed [2*XW-1:0] p1, p2;
  logic signed [YW-1:0]   y_c;
  logic signed [EW-1:0]   e_c;
  logic signed [XW-1:0]   x2;
  logic                   adapt;

  function automatic logic signed [XW-1:0] step_w(
    input logic signed [XW-1:0] w,
    input logic signed [XW-1:0] x,
    input logic signed [EW-1:0] e
  );
    logic signed [PW-1:0] full;
    logic signed [PW-1:0] q;
    logic signed [PW:0]   sum;
    full = PW'(MU) * PW'(x) * PW'(e);
    q    = (full + (PW'(1) <<< (SH - 1))) >>> SH;
    sum  = (PW+1)'(w) + (PW+1)'(q);
    if (sum > (PW+1)'(WMAX))      step_w = WMAX;
    else if (sum < (PW+1)'(WMIN)) step_w = WMIN;
    else                          step_w = XW'(sum);
  endfunction

  assign x2    = dly_q[DLY-1];
  assign p1    = smp_x * w1_q;
  assign p2    = x2 * w2_q;
  assign y_c   = YW'(p1) + YW'(p2);
  assign e_c   = EW'(y_c) - EW'(smp_ref);
  assign adapt = cnt_q < CW'(MAX_UPD);

  always_ff @(posedge clk) begin
    if (rst) begin
      w1_q    <= '0;
      w2_q    <= '0;
      cnt_q   <= '0;
      out_vld <= 1'b0;
      out_y   <= '0;
      out_err <= '0;
      for (int i = 0; i < DLY; i++) dly_q[i] <= '0;
    end else begin
      out_vld <= smp_vld;
      if (smp_vld) begin
        out_y    <= y_c;
        out_err  <= e_c;
        dly_q[0] <= smp_x;
        for (int i = 1; i < DLY; i++) dly_q[i] <= dly_q[i-1];
        if (adapt) begin
          w1_q  <= step_w(w1_q, smp_x, e_c);
          w2_q  <= step_w(w2_q, x2, e_c);
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign out_w1 = w1_q;
  assign out_w2 = w2_q;

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst) smp_vld |=> out_vld); // R2
  AST_VLD_DROPS: assert property (@(posedge clk) disable iff (rst) !smp_vld |=> !out_vld); // R2
  AST_ERR_REF: assert property (@(posedge clk) disable iff (rst)
    smp_vld |=> (out_err == EW'(out_y) - EW'($past(smp_ref)))); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> ($stable(w1_q) && $stable(w2_q) && $stable(out_y) && $stable(out_err))); // R10
  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CW'(MAX_UPD)) |=> ($stable(w1_q) && $stable(w2_q))); // R9
  AST_CNT_CAP: assert property (@(posedge clk) disable iff (rst) cnt_q <= CW'(MAX_UPD)); // R9
endmodule

// File: tb/lms2_core_bench.sv
module lms2_core_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_vld = 1'b0;
  logic signed [11:0] smp_x = '0;
  logic signed [24:0] smp_ref = '0;
  logic out_vld;
  logic signed [24:0] out_y;
  logic signed [25:0] out_err;
  logic signed [11:0] out_w1, out_w2;

  int tests = 0;
  int fails = 0;

  longint mw1, mw2;
  int     mcnt;
  longint hist[$];

  always #2 clk = ~clk;

  lms2_core u_lms2_core (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_x(smp_x), .smp_ref(smp_ref),
    .out_vld(out_vld), .out_y(out_y), .out_err(out_err), .out_w1(out_w1), .out_w2(out_w2)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint sat12(input longint v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  function automatic longint upd(input longint w, input longint x, input longint e);
    longint inc;
    inc = 2 * x * e;
    return sat12(w + ((inc + 16384) >>> 15));
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; smp_vld = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    mw1 = 0; mw2 = 0; mcnt = 0; hist.delete();
  endtask

  task automatic do_strobe(input longint x, input longint r, input string wreq);
    longint x2, y, e;
    x2 = (hist.size() >= 30) ? hist[hist.size() - 30] : 0;
    y = x * mw1 + x2 * mw2;
    e = y - r;
    if (mcnt < 1000) begin
      mw1 = upd(mw1, x, e);
      mw2 = upd(mw2, x2, e);
      mcnt++;
    end
    hist.push_back(x);
    smp_vld = 1'b1; smp_x = 12'(x); smp_ref = 25'(r);
    @(posedge clk);
    @(negedge clk);
    smp_vld = 1'b0;
    chk("R2", "out_vld", longint'(out_vld), 1);
    chk("R3", "out_y", longint'(out_y), y);
    chk("R4", "out_err", longint'(out_err), e);
    chk(wreq, "out_w1", longint'(out_w1), mw1);
    chk(wreq, "out_w2", longint'(out_w2), mw2);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "out_vld", longint'(out_vld), 0);
    chk("R1", "out_y", longint'(out_y), 0);
    chk("R1", "out_err", longint'(out_err), 0);
    chk("R1", "out_w1", longint'(out_w1), 0);
    chk("R1", "out_w2", longint'(out_w2), 0);
  endtask

  task automatic t_round();
    do_reset();
    do_strobe(1, -8192, "R6");
    chk("R6", "tie rounds up", longint'(out_w1), 1);
    do_reset();
    do_strobe(1, 8192, "R6");
    chk("R6", "negative tie rounds up", longint'(out_w1), 0);
    do_reset();
    do_strobe(1, -8191, "R6");
    chk("R6", "below tie", longint'(out_w1), 0);
  endtask

  task automatic t_basic();
    do_reset();
    for (int n = 0; n < 40; n++)
      do_strobe(longint'((n * 37) % 200) - 100, longint'((n * 53) % 4000) - 2000, "R5");
  endtask

  task automatic t_idle();
    longint w1s, w2s, ys;
    w1s = longint'(out_w1); w2s = longint'(out_w2); ys = longint'(out_y);
    smp_x = 12'sd700; smp_ref = 25'sd99999;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R2", "out_vld idle", longint'(out_vld), 0);
      chk("R10", "w1 idle", longint'(out_w1), w1s);
      chk("R10", "w2 idle", longint'(out_w2), w2s);
      chk("R10", "y idle", longint'(out_y), ys);
    end
  endtask

  task automatic t_sat();
    do_reset();
    do_strobe(2047, -16777216, "R7");
    chk("R7", "positive limit", longint'(out_w1), 2047);
    do_strobe(2047, 16777215, "R7");
    do_strobe(-2048, -16777216, "R7");
    do_strobe(2047, 16777215, "R7");
    chk("R7", "negative limit", longint'(out_w1), -2048);
  endtask

  task automatic t_delay();
    do_reset();
    do_strobe(1500, 0, "R8");
    for (int n = 1; n < 30; n++) begin
      do_strobe(64, -300000, "R8");
      chk("R8", "w2 zero before tap filled", longint'(out_w2), 0);
    end
    do_strobe(0, -300000, "R8");
    chk("R8", "w2 moves with delayed sample", longint'(out_w2 != 0), 1);
  endtask

  task automatic t_freeze();
    longint w1s, w2s;
    do_reset();
    for (int n = 0; n < 1000; n++)
      do_strobe(longint'((n * 29) % 120) - 60, longint'((n * 71) % 3000) - 1500, "R5");
    w1s = longint'(out_w1); w2s = longint'(out_w2);
    for (int n = 0; n < 5; n++) begin
      do_strobe(500, -400000, "R9");
      chk("R9", "w1 frozen", longint'(out_w1), w1s);
      chk("R9", "w2 frozen", longint'(out_w2), w2s);
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_round();
    t_basic();
    t_idle();
    t_sat();
    t_delay();
    t_freeze();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule